// File: doc/BRIEF.md
# Split Analog/Digital Output Attenuation Controller

This block sits in an audio playback path just before the converter. It takes a 5-bit attenuation setting that asks for 0 to 69 dB of loss in 3 dB increments, plus a mute control. It splits the setting into two parts. The fine remainder, from 0 to 21 dB, goes out as a 3-bit code to an external analog attenuator. The coarse quotient, 0, 24 or 48 dB, is applied to the sample stream as a sign-preserving arithmetic right shift of 4 or 8 bits. Leaving the digital word unscaled at the eight gentlest settings keeps the word at full resolution where listening is most critical.

Samples arrive as signed 12-bit values qualified by a valid strobe. Each sample comes out one clock later together with the analog code and the mute flag that apply to it. The setting and the mute control are sampled only on cycles that carry a valid sample. A change between samples therefore never splits one sample across two settings. Under mute the stream keeps its cadence but every emitted sample is zero.

Top module: `atten_split_ctrl`

## Requirements
- R1: After a clock edge with rst_n low, out_valid, out_sample, ana_code and mute_out are all 0.
- R2: out_valid is high exactly in the cycle after each cycle in which in_valid is high, so every input sample yields exactly one output sample.
- R3: For settings 0 to 7 the sample passes unchanged and ana_code equals the setting.
- R4: For settings 8 to 15 the sample is arithmetically shifted right by 4 bits and ana_code equals the setting minus 8.
- R5: For settings 16 to 23 the sample is arithmetically shifted right by 8 bits and ana_code equals the setting minus 16.
- R6: Settings 24 to 31 behave exactly like setting 23: ana_code is 7 and the shift is 8 bits.
- R7: Digital scaling rounds toward negative infinity and never changes the sign bit (for example -1 stays -1, and -17 shifted by 4 gives -2).
- R8: While mute_in is high on a valid input cycle, the matching output sample is 0, out_valid still pulses, and mute_out is 1. With mute_in low, mute_out is 0.
- R9: Changes to atten_code or mute_in on cycles without in_valid leave out_sample, ana_code and mute_out unchanged.
- R10: ana_code and mute_out change in the same cycle as the output sample they belong to, and they take the setting present on that sample's input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| atten_code | input | 5 | Attenuation setting, 3 dB per step; values above 23 are clamped |
| mute_in | input | 1 | Force output samples to zero |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 12 | Signed two's complement input sample |
| out_valid | output | 1 | Output sample strobe, one cycle after in_valid |
| out_sample | output | 12 | Signed scaled or muted sample |
| ana_code | output | 3 | Fine attenuation code for the analog stage, 0 to 7 |
| mute_out | output | 1 | Mute state belonging to the current output sample |

## Verification
A change of setting and a mute toggle can land on the same valid input cycle as a sample, in either order relative to a run of back-to-back samples. The bench provokes both by changing atten_code and mute_in together on the very cycle a sample is strobed, and again while the strobe is low. It then judges each output sample against the scaled or zeroed value and the analog code that the setting present on its own input cycle predicts. It also confirms that the outputs hold still across the cycles in which no sample is strobed.

// File: rtl/atten_pkg.sv
// Package: shared defaults for the split attenuation controller.
// Assumes one attenuation step is 3 dB and a coarse step is eight fine steps.
package atten_pkg;
    localparam int SAMPLE_W_DEF   = 12;
    localparam int CODE_W_DEF     = 5;
    localparam int FINE_STEPS_DEF = 8;
    localparam int MAX_CODE_DEF   = 23;
    localparam int SHIFT_PER_DEF  = 4;
endpackage

// File: rtl/atten_code_split.sv
// Clamps the attenuation setting to MAX_CODE, then splits it into a fine
// (analog) remainder and a coarse (digital) quotient.
// Assumes MAX_CODE fits in CODE_W bits.
module atten_code_split #(
    parameter int CODE_W     = 5,
    parameter int FINE_STEPS = 8,
    parameter int MAX_CODE   = 23,
    localparam int FINE_W    = $clog2(FINE_STEPS),
    localparam int COARSE_N  = (MAX_CODE / FINE_STEPS) + 1,
    localparam int COARSE_W  = (COARSE_N > 1) ? $clog2(COARSE_N) : 1
) (
    input  logic [CODE_W-1:0]   code_i,
    output logic [FINE_W-1:0]   fine_o,
    output logic [COARSE_W-1:0] coarse_o
);
    localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_CODE);

    logic [CODE_W-1:0] clamped;

    // Limit out-of-range settings and derive remainder and quotient.
    always_comb begin
        clamped  = (code_i > MAX_C) ? MAX_C : code_i;
        fine_o   = FINE_W'(int'(clamped) % FINE_STEPS);
        coarse_o = COARSE_W'(int'(clamped) / FINE_STEPS);
    end
endmodule

// File: rtl/atten_coarse_shift.sv
// Applies the coarse digital attenuation as an arithmetic right shift of
// step * SHIFT_PER bits. Rounds toward negative infinity and keeps the sign.
// Assumes step_i never exceeds COARSE_N-1; larger values use the deepest step.
module atten_coarse_shift #(
    parameter int DATA_W    = 12,
    parameter int COARSE_N  = 3,
    parameter int COARSE_W  = 2,
    parameter int SHIFT_PER = 4
) (
    input  logic signed [DATA_W-1:0] sample_i,
    input  logic [COARSE_W-1:0]      step_i,
    output logic signed [DATA_W-1:0] sample_o
);
    logic signed [DATA_W-1:0] cand [COARSE_N];

    // One pre-shifted candidate per coarse step.
    for (genvar g = 0; g < COARSE_N; g++) begin : g_step
        assign cand[g] = sample_i >>> (g * SHIFT_PER);
    end

    // Select the candidate for the requested step, saturating the index.
    always_comb begin
        sample_o = cand[COARSE_N-1];
        for (int k = 0; k < COARSE_N; k++) begin
            if (int'(step_i) == k) sample_o = cand[k];
        end
    end
endmodule

// File: rtl/atten_out_reg.sv
// Output register stage: captures sample, analog code and mute together on
// each valid input cycle and holds them otherwise. Under mute the sample is
// replaced by zero. Synchronous active-low reset.
module atten_out_reg #(
    parameter int DATA_W = 12,
    parameter int FINE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  logic                     mute_i,
    input  logic signed [DATA_W-1:0] sample_i,
    input  logic [FINE_W-1:0]        fine_i,
    output logic                     valid_o,
    output logic signed [DATA_W-1:0] sample_o,
    output logic [FINE_W-1:0]        fine_o,
    output logic                     mute_o
);
    // Strobe follows the input strobe by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= valid_i;
    end

    // Settings and data move only with a valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= '0;
            fine_o   <= '0;
            mute_o   <= 1'b0;
        end else if (valid_i) begin
            sample_o <= mute_i ? '0 : sample_i;
            fine_o   <= fine_i;
            mute_o   <= mute_i;
        end
    end
endmodule

// File: rtl/atten_split_ctrl.sv
// Top: split analog/digital output attenuation controller.
// Fine 3 dB steps leave as ana_code; whole coarse steps are applied to the
// sample word. One clock of latency; settings sampled with each valid sample.
module atten_split_ctrl #(
    parameter int SAMPLE_W   = atten_pkg::SAMPLE_W_DEF,
    parameter int CODE_W     = atten_pkg::CODE_W_DEF,
    parameter int FINE_STEPS = atten_pkg::FINE_STEPS_DEF,
    parameter int MAX_CODE   = atten_pkg::MAX_CODE_DEF,
    parameter int SHIFT_PER  = atten_pkg::SHIFT_PER_DEF,
    localparam int FINE_W    = $clog2(FINE_STEPS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CODE_W-1:0]          atten_code,
    input  logic                       mute_in,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_sample,
    output logic [FINE_W-1:0]          ana_code,
    output logic                       mute_out
);
    localparam int COARSE_N = (MAX_CODE / FINE_STEPS) + 1;
    localparam int COARSE_W = (COARSE_N > 1) ? $clog2(COARSE_N) : 1;

    logic [FINE_W-1:0]          fine;
    logic [COARSE_W-1:0]        coarse;
    logic signed [SAMPLE_W-1:0] scaled;

    atten_code_split #(
        .CODE_W     (CODE_W),
        .FINE_STEPS (FINE_STEPS),
        .MAX_CODE   (MAX_CODE)
    ) u_split (
        .code_i   (atten_code),
        .fine_o   (fine),
        .coarse_o (coarse)
    );

    atten_coarse_shift #(
        .DATA_W    (SAMPLE_W),
        .COARSE_N  (COARSE_N),
        .COARSE_W  (COARSE_W),
        .SHIFT_PER (SHIFT_PER)
    ) u_shift (
        .sample_i (in_sample),
        .step_i   (coarse),
        .sample_o (scaled)
    );

    atten_out_reg #(
        .DATA_W (SAMPLE_W),
        .FINE_W (FINE_W)
    ) u_oreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (in_valid),
        .mute_i   (mute_in),
        .sample_i (scaled),
        .fine_i   (fine),
        .valid_o  (out_valid),
        .sample_o (out_sample),
        .fine_o   (ana_code),
        .mute_o   (mute_out)
    );
endmodule

// File: rtl/atten_split_chk.sv
// Checker for atten_split_ctrl, attached with bind. Observes ports only.
module atten_split_chk #(
    parameter int SAMPLE_W = 12,
    parameter int CODE_W   = 5,
    parameter int FINE_W   = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [CODE_W-1:0]          atten_code,
    input logic                       mute_in,
    input logic                       in_valid,
    input logic signed [SAMPLE_W-1:0] in_sample,
    input logic                       out_valid,
    input logic signed [SAMPLE_W-1:0] out_sample,
    input logic [FINE_W-1:0]          ana_code,
    input logic                       mute_out
);
    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mute_in && atten_code == '0) |=> out_sample == $past(in_sample));
    // R6
    clamp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && atten_code >= CODE_W'(23)) |=> ana_code == FINE_W'(7));
    // R7
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mute_in) |=> out_sample[SAMPLE_W-1] == $past(in_sample[SAMPLE_W-1]));
    // R8
    mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mute_out) |-> out_sample == '0);
    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_sample) && $stable(ana_code) && $stable(mute_out)));
    // R10
    mute_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> mute_out == $past(mute_in));
endmodule

bind atten_split_ctrl atten_split_chk #(
    .SAMPLE_W (SAMPLE_W),
    .CODE_W   (CODE_W),
    .FINE_W   (FINE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .atten_code (atten_code),
    .mute_in    (mute_in),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .ana_code   (ana_code),
    .mute_out   (mute_out)
);

// File: tb/sim_atten_split_ctrl.sv
// Scoreboard bench: driver pushes expected results, monitor pops and compares.
module sim_atten_split_ctrl;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        atten_code = '0;
    logic              mute_in = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [11:0] in_sample = '0;
    logic              out_valid;
    logic signed [11:0] out_sample;
    logic [2:0]        ana_code;
    logic              mute_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic signed [11:0] s;
        logic [2:0]         a;
        bit                 m;
        string              tag;
    } exp_t;
    exp_t sb [$];

    always #2.5 clk = ~clk;

    atten_split_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .atten_code(atten_code), .mute_in(mute_in),
        .in_valid(in_valid), .in_sample(in_sample), .out_valid(out_valid),
        .out_sample(out_sample), .ana_code(ana_code), .mute_out(mute_out)
    );

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Driver: one valid sample, expected result pushed to the scoreboard.
    task automatic send(int code, bit m, logic signed [11:0] s, string tag);
        exp_t e;
        int c;
        @(negedge clk);
        c = (code > 23) ? 23 : code;
        e.a = 3'(c % 8);
        e.m = m;
        e.s = m ? 12'sd0 : (s >>> (4 * (c / 8)));
        e.tag = tag;
        sb.push_back(e);
        atten_code = 5'(code);
        mute_in = m;
        in_sample = s;
        in_valid = 1'b1;
    endtask

    // Idle cycles with setting changes; outputs must hold (R9).
    task automatic idle_change(int code, bit m);
        logic signed [11:0] hs;
        logic [2:0] ha;
        logic hm;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        hs = out_sample; ha = ana_code; hm = mute_out;
        atten_code = 5'(code);
        mute_in = m;
        in_sample = 12'sh555;
        @(negedge clk);
        @(negedge clk);
        check(out_sample == hs, "R9", "held sample", int'(out_sample), int'(hs));
        check(ana_code == ha, "R9", "held ana_code", int'(ana_code), int'(ha));
        check(mute_out == hm, "R9", "held mute", int'(mute_out), int'(hm));
        check(!out_valid, "R2", "no strobe while idle", int'(out_valid), 0);
    endtask

    // Monitor: compare each output sample with the scoreboard head (R2, R10).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_sample == e.s, e.tag, "out_sample", int'(out_sample), int'(e.s));
                check(ana_code == e.a, e.tag, "ana_code", int'(ana_code), int'(e.a));
                check(mute_out == e.m, e.tag, "mute_out", int'(mute_out), int'(e.m));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
        check(out_sample == 12'sd0, "R1", "out_sample", int'(out_sample), 0);
        check(ana_code == 3'd0, "R1", "ana_code", int'(ana_code), 0);
        check(mute_out == 1'b0, "R1", "mute_out", int'(mute_out), 0);
        rst_n = 1'b1;

        // R3: fine range, sample unchanged
        send(0, 0, 12'sd2047, "R3");
        send(5, 0, -12'sd2048, "R3");
        send(7, 0, 12'sd123, "R3");
        // R4: first coarse step
        send(8, 0, 12'sd1600, "R4");
        send(12, 0, -12'sd17, "R7");
        send(15, 0, 12'sd15, "R4");
        // R5: second coarse step
        send(16, 0, 12'sd2047, "R5");
        send(20, 0, -12'sd2048, "R5");
        send(23, 0, -12'sd1, "R7");
        // R6: clamp
        send(24, 0, 12'sd1000, "R6");
        send(31, 0, -12'sd300, "R6");
        idle_change(3, 1);
        // R8: mute with running strobe, setting change in the same cycle
        send(2, 1, 12'sd900, "R8");
        send(17, 1, -12'sd900, "R8");
        send(17, 0, -12'sd900, "R10");
        send(1, 0, 12'sd900, "R10");
        idle_change(30, 0);
        send(9, 0, -12'sd1, "R7");
        send(9, 1, 12'sd5, "R8");
        idle_change(0, 0);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2", "samples outstanding", sb.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule